// File: doc/BRIEF.md
# Sigma-Delta Overcurrent and Zero-Cross Detector

This block guards a phase current measured by a sigma-delta modulator. It sits beside the normal sampling path and runs its own third-order sinc decimator from the raw modulator bitstream. The decimator never stops while the block is enabled. Each new decimated value is checked against one upper limit and one lower limit. A value outside the window raises a trip request, which goes to the PWM trip-zone logic. The block also flips a zero-cross output whenever the filtered current changes sign.

The modulator clock and data are taken in as plain inputs and sampled in the system clock domain. Only rising edges of the modulator clock advance the filter. After enable, a fixed settling window of modulator edges must pass before any value is compared. Trip flags are sticky. Software or a supervisor removes them with a clear pulse, and the pulse only works once the overcurrent has gone away. A registered OR of both flags gives a single glitch-free trip line.

Top module: `sd_ocd_guard`

## Requirements
- R1: After reset, `trip_hi`, `trip_lo`, `trip_any` and `zc_toggle` are all 0.
- R2: While `en` is 1, each rising edge of `mod_clk` takes one bit from `mod_data`: 1 counts as +1 and 0 counts as -1. A third-order sinc decimator produces one signed value every N edges, where N is the effective oversampling ratio. A constant stream settles to +N^3 for all ones and to -N^3 for all zeros.
- R3: The effective ratio is `osr` limited to the range 8 to 256. Settings below 8 act as 8 and settings above 256 act as 256.
- R4: A value produced on or before the 32nd rising `mod_clk` edge after `en` goes high is never compared and never used for zero-cross detection. While `en` is 0, the filter and the settling count are held cleared.
- R5: A compared value strictly greater than `thr_high` sets `trip_hi`. A value equal to `thr_high` does not set it.
- R6: A compared value strictly less than `thr_low` sets `trip_lo`. A value equal to `thr_low` does not set it.
- R7: Trip flags stay set until a `trip_clear` pulse arrives while the latest compared value no longer violates that limit. A clear pulse is ignored while the violation persists. Dropping `en` keeps the flags but discards the latest violation, so a later clear succeeds.
- R8: `trip_any` equals the OR of `trip_hi` and `trip_lo`, delayed by one register.
- R9: `zc_toggle` inverts when the sign of a compared value differs from the sign of the previous compared value. A value of exactly zero counts as positive. The first compared value after enable only sets the reference and does not invert the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low clears the filter and the settling count |
| osr | input | 9 | Requested oversampling ratio |
| thr_high | input | 26 | Signed upper limit |
| thr_low | input | 26 | Signed lower limit |
| trip_clear | input | 1 | One-cycle request to drop trip flags |
| mod_clk | input | 1 | Modulator clock, sampled in the `clk` domain |
| mod_data | input | 1 | Modulator bitstream |
| trip_hi | output | 1 | Sticky upper-limit trip |
| trip_lo | output | 1 | Sticky lower-limit trip |
| trip_any | output | 1 | Registered OR of both trips |
| zc_toggle | output | 1 | Inverts on each sign change |

## Verification
The hardest states to reach from the ports are the exact filter outputs that sit on a limit and the edge-by-edge position of the settling window. The stimulus uses constant all-ones, all-zeros and alternating streams, because their settled filter values are known in closed form: ±N^3 and exactly 0. This allows limits to be placed one count either side of the settled value. It also allows streams to stop exactly at the 32nd edge or shortly after it. The alternating stream settles to exactly zero, so the sign change seen when leaving a negative region shows that zero is treated as positive.

// File: rtl/sd_ocd_guard.sv
module sd_ocd_guard #(
  parameter int OSR_MIN = 8,
  parameter int OSR_MAX = 256,
  parameter int BLANK   = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   en,
  input  logic [$clog2(OSR_MAX):0]               osr,
  input  logic signed [3*$clog2(OSR_MAX)+1:0]    thr_high,
  input  logic signed [3*$clog2(OSR_MAX)+1:0]    thr_low,
  input  logic                                   trip_clear,
  input  logic                                   mod_clk,
  input  logic                                   mod_data,
  output logic                                   trip_hi,
  output logic                                   trip_lo,
  output logic                                   trip_any,
  output logic                                   zc_toggle
);
  localparam int OSR_W = $clog2(OSR_MAX) + 1;
  localparam int DW    = 3 * $clog2(OSR_MAX) + 2;
  localparam int BW    = $clog2(BLANK + 1);

  logic [2:0] mclk_s;
  logic [1:0] mdat_s;
  logic       rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mclk_s <= '0;
      mdat_s <= '0;
    end else begin
      mclk_s <= {mclk_s[1:0], mod_clk};
      mdat_s <= {mdat_s[0], mod_data};
    end

  assign rise = mclk_s[1] & ~mclk_s[2];

  logic [OSR_W-1:0] eff_osr;
  assign eff_osr = (osr < OSR_W'(OSR_MIN)) ? OSR_W'(OSR_MIN) :
                   (osr > OSR_W'(OSR_MAX)) ? OSR_W'(OSR_MAX) : osr;

  logic signed [DW-1:0] x, i1, i2, i3, i1n, i2n, i3n;
  logic signed [DW-1:0] c1, c2, c3, d1, d2, d3, val;
  logic [OSR_W-1:0]     dec_cnt;
  logic [BW-1:0]        blank_cnt;
  logic                 last, armed, cmp_go;

  assign x     = mdat_s[1] ? DW'(1) : '1;
  assign i1n   = i1 + x;
  assign i2n   = i2 + i1n;
  assign i3n   = i3 + i2n;
  assign d1    = i3n - c1;
  assign d2    = d1 - c2;
  assign d3    = d2 - c3;
  assign last  = dec_cnt >= eff_osr - OSR_W'(1);
  assign armed = blank_cnt == BW'(BLANK);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      i1 <= '0; i2 <= '0; i3 <= '0;
      c1 <= '0; c2 <= '0; c3 <= '0;
      val <= '0; dec_cnt <= '0; blank_cnt <= '0; cmp_go <= 1'b0;
    end else if (!en) begin
      i1 <= '0; i2 <= '0; i3 <= '0;
      c1 <= '0; c2 <= '0; c3 <= '0;
      dec_cnt <= '0; blank_cnt <= '0; cmp_go <= 1'b0;
    end else begin
      cmp_go <= 1'b0;
      if (rise) begin
        i1 <= i1n;
        i2 <= i2n;
        i3 <= i3n;
        if (!armed) blank_cnt <= blank_cnt + BW'(1);
        if (last) begin
          dec_cnt <= '0;
          c1 <= i3n;
          c2 <= d1;
          c3 <= d2;
          val <= d3;
          cmp_go <= armed;
        end else begin
          dec_cnt <= dec_cnt + OSR_W'(1);
        end
      end
    end

  logic gt, lt, hi_cond, lo_cond, has_ref, ref_neg, neg;
  assign gt  = val > thr_high;
  assign lt  = val < thr_low;
  assign neg = val[DW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_cond <= 1'b0; lo_cond <= 1'b0;
      trip_hi <= 1'b0; trip_lo <= 1'b0; trip_any <= 1'b0;
      has_ref <= 1'b0; ref_neg <= 1'b0; zc_toggle <= 1'b0;
    end else begin
      trip_hi  <= (cmp_go & gt) | (trip_hi & ~(trip_clear & ~hi_cond));
      trip_lo  <= (cmp_go & lt) | (trip_lo & ~(trip_clear & ~lo_cond));
      trip_any <= trip_hi | trip_lo;
      if (!en) begin
        hi_cond <= 1'b0;
        lo_cond <= 1'b0;
        has_ref <= 1'b0;
      end else if (cmp_go) begin
        hi_cond <= gt;
        lo_cond <= lt;
        has_ref <= 1'b1;
        ref_neg <= neg;
        if (has_ref && (neg != ref_neg)) zc_toggle <= ~zc_toggle;
      end
    end

  // R4
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |-> blank_cnt == BW'(BLANK));

  // R5
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_hi) |-> $past(cmp_go));

  // R6
  lo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_lo) |-> $past(cmp_go));

  // R7
  hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_hi) |-> ($past(trip_clear) && !$past(hi_cond)));

  // R7
  lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_lo) |-> ($past(trip_clear) && !$past(lo_cond)));

  // R8
  any_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_any) |-> $past(trip_hi || trip_lo));

  // R9
  zc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_toggle != $past(zc_toggle)) |-> $past(cmp_go));
endmodule

// File: tb/sd_ocd_guard_tb.sv
module sd_ocd_guard_tb;
  localparam int DW = 26;
  localparam int NV = 13;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, trip_clear = 1'b0;
  logic mod_clk = 1'b0, mod_data = 1'b0;
  logic [8:0] osr = 9'd8;
  logic signed [DW-1:0] thr_high = '0, thr_low = '0;
  logic trip_hi, trip_lo, trip_any, zc_toggle;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sd_ocd_guard u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .osr(osr),
    .thr_high(thr_high), .thr_low(thr_low), .trip_clear(trip_clear),
    .mod_clk(mod_clk), .mod_data(mod_data),
    .trip_hi(trip_hi), .trip_lo(trip_lo), .trip_any(trip_any),
    .zc_toggle(zc_toggle)
  );

  // pattern: 0 all zeros, 1 all ones, 2 alternating starting with 1
  localparam int V_OSR [NV] = '{8, 8, 8, 8, 8, 8, 8, 3, 16, 256, 256, 8, 300};
  localparam int V_HI  [NV] = '{100, 100, 600, 512, 511, 600, 600, 100, 4095,
                                16777216, 16777215, 100, 16777216};
  localparam int V_LO  [NV] = '{-600, -600, -100, -600, -600, -512, -511, -600,
                                -600, -600, -600, -100, -600};
  localparam int V_PAT [NV] = '{1, 1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 2, 1};
  localparam int V_N   [NV] = '{32, 40, 40, 40, 40, 40, 40, 40, 48, 768, 768, 64, 768};
  localparam bit V_EH  [NV] = '{0, 1, 0, 0, 1, 0, 0, 1, 1, 0, 1, 0, 0};
  localparam bit V_EL  [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
  localparam string V_TAG [NV] = '{"R4 blank", "R4 armed", "R6 low", "R5 equal",
    "R5 above", "R6 equal", "R6 below", "R3 osr low", "R2 osr16",
    "R5 osr256 equal", "R5 osr256 above", "R2 alternating", "R3 osr high"};

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send(bit b);
    mod_data = b;
    mod_clk  = 1'b0;
    repeat (5) @(negedge clk);
    mod_clk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic feed(int pat, int n);
    for (int k = 0; k < n; k++)
      send(pat == 2 ? (k % 2 == 0) : (pat == 1));
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk) trip_clear = 1'b1;
    @(negedge clk) trip_clear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic restart(int o, int hi, int lo);
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
    pulse_clear();
    osr = 9'(o);
    thr_high = DW'(hi);
    thr_low  = DW'(lo);
    @(negedge clk) en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic z0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 trip_hi", trip_hi, 1'b0);
    chk("R1 trip_lo", trip_lo, 1'b0);
    chk("R1 trip_any", trip_any, 1'b0);
    chk("R1 zc_toggle", zc_toggle, 1'b0);

    for (int i = 0; i < NV; i++) begin
      restart(V_OSR[i], V_HI[i], V_LO[i]);
      feed(V_PAT[i], V_N[i]);
      chk({V_TAG[i], " hi"}, trip_hi, V_EH[i]);
      chk({V_TAG[i], " lo"}, trip_lo, V_EL[i]);
      chk({V_TAG[i], " R8 any"}, trip_any, V_EH[i] | V_EL[i]);
    end

    // R7 clear refused while over limit, accepted once back inside
    restart(8, 100, -600);
    feed(1, 40);
    chk("R7 set", trip_hi, 1'b1);
    pulse_clear();
    chk("R7 clear ignored", trip_hi, 1'b1);
    feed(2, 32);
    chk("R7 still sticky", trip_hi, 1'b1);
    pulse_clear();
    chk("R7 cleared", trip_hi, 1'b0);
    @(negedge clk);
    chk("R8 any cleared", trip_any, 1'b0);

    // R7 flags survive disable, then clear works
    feed(1, 32);
    chk("R7 retrip", trip_hi, 1'b1);
    @(negedge clk) en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 held while disabled", trip_hi, 1'b1);
    pulse_clear();
    chk("R7 clear after disable", trip_hi, 1'b0);

    // R9 zero-cross behaviour
    restart(8, 100000, -100000);
    z0 = zc_toggle;
    feed(1, 40);
    chk("R9 first value no toggle", zc_toggle, z0);
    feed(0, 24);
    chk("R9 pos to neg toggles", zc_toggle, ~z0);
    feed(0, 16);
    chk("R9 steady negative holds", zc_toggle, ~z0);
    feed(2, 32);
    chk("R9 zero counts positive", zc_toggle, z0);
    chk("R9 no trips", trip_hi | trip_lo, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule